// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one bit-level operation per clock on a byte operand. The bit position comes from a small immediate. The carry flag works as a one-bit accumulator. An operation can copy a chosen bit into carry, write carry (or its complement) into that bit, or combine the bit with carry through AND, OR or XOR. Each of those forms also has an inverted variant. Plain test, set, clear and flip operations are also supported, and test reports its outcome through the zero flag.

The surrounding datapath supplies the operand byte, the bit index, the operation code and the present carry and zero flags. One clock later the unit returns the resulting byte, a store-enable that says whether the byte must be written back, and the next carry and zero flags. Fetching and writing the operand in memory is left to the caller.

Top module: `bitop_unit`

## Requirements
- R1: While reset is active, `data_out`, `store_en`, `c_out` and `z_out` are all 0.
- R2: Outputs are registered. The inputs present at a rising clock edge determine the outputs that appear after that edge.
- R3: The target bit is the one whose position equals `bit_idx`. Every other bit of `data_out` equals the same bit of `data_in`, and when `store_en` is 0 the whole of `data_out` equals `data_in`.
- R4: Test (op code 0) drives `z_out` to 1 when the target bit is 0 and to 0 when it is 1. It does not store.
- R5: Load (op code 1) sets `c_out` to the target bit. Inverted load (op code 2) sets `c_out` to the complement of the target bit. Neither stores.
- R6: Store-carry (op code 3) writes `c_in` into the target bit. Inverted store-carry (op code 4) writes the complement of `c_in`.
- R7: Set (op code 5) writes 1, clear (op code 6) writes 0, and flip (op code 7) writes the complement of the target bit.
- R8: Op codes 8, 10 and 12 write (bit AND carry), (bit OR carry) and (bit XOR carry) into the target bit. Op codes 9, 11 and 13 write the complement of the same three results.
- R9: `store_en` is 1 exactly for op codes 3 to 13.
- R10: Every op code except 0 passes `z_in` to `z_out`. Every op code except 1 and 2 passes `c_in` to `c_out`.
- R11: The reserved op codes 14 and 15 act as no-ops. The byte passes through unchanged, `store_en` is 0, and both flags pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation code (see requirements) |
| bit_idx | input | 3 | Position of the target bit |
| data_in | input | 8 | Operand byte |
| c_in | input | 1 | Present carry flag |
| z_in | input | 1 | Present zero flag |
| data_out | output | 8 | Resulting byte |
| store_en | output | 1 | Byte must be written back |
| c_out | output | 1 | Next carry flag |
| z_out | output | 1 | Next zero flag |

## Verification
Two functions can meet in a single cycle: the unit writes a bit, and in the same cycle it consumes a carry that the previous operation just produced. The bench provokes this with chained sequences. The registered `c_out` is fed back as `c_in` on the next cycle, so a load is followed at once by a store-carry or a carry-logic operation. The reference model keeps its own carry, and each cycle's byte and flags are compared against that model. A stale or misrouted carry therefore shows up as a wrong bit at the target position.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    BOP_TEST  = 4'd0,
    BOP_LOAD  = 4'd1,
    BOP_LOADN = 4'd2,
    BOP_STC   = 4'd3,
    BOP_STCN  = 4'd4,
    BOP_SET   = 4'd5,
    BOP_CLR   = 4'd6,
    BOP_FLIP  = 4'd7,
    BOP_AND   = 4'd8,
    BOP_ANDN  = 4'd9,
    BOP_OR    = 4'd10,
    BOP_ORN   = 4'd11,
    BOP_XOR   = 4'd12,
    BOP_XORN  = 4'd13
  } bop_e;

  typedef struct packed {
    logic wr;       // byte must be written back
    logic bit_val;  // new value of the target bit
    logic c_val;    // next carry
    logic z_val;    // next zero
  } bop_res_t;

  // Per-operation behaviour on the selected bit and the flags.
  function automatic bop_res_t bop_eval(input logic [3:0] op,
                                        input logic sel,
                                        input logic c_cur,
                                        input logic z_cur);
    bop_res_t r;
    r.wr      = 1'b0;
    r.bit_val = sel;
    r.c_val   = c_cur;
    r.z_val   = z_cur;
    case (op)
      BOP_TEST:  r.z_val = ~sel;
      BOP_LOAD:  r.c_val = sel;
      BOP_LOADN: r.c_val = ~sel;
      BOP_STC:   begin r.wr = 1'b1; r.bit_val = c_cur;          end
      BOP_STCN:  begin r.wr = 1'b1; r.bit_val = ~c_cur;         end
      BOP_SET:   begin r.wr = 1'b1; r.bit_val = 1'b1;           end
      BOP_CLR:   begin r.wr = 1'b1; r.bit_val = 1'b0;           end
      BOP_FLIP:  begin r.wr = 1'b1; r.bit_val = ~sel;           end
      BOP_AND:   begin r.wr = 1'b1; r.bit_val = sel & c_cur;    end
      BOP_ANDN:  begin r.wr = 1'b1; r.bit_val = ~(sel & c_cur); end
      BOP_OR:    begin r.wr = 1'b1; r.bit_val = sel | c_cur;    end
      BOP_ORN:   begin r.wr = 1'b1; r.bit_val = ~(sel | c_cur); end
      BOP_XOR:   begin r.wr = 1'b1; r.bit_val = sel ^ c_cur;    end
      BOP_XORN:  begin r.wr = 1'b1; r.bit_val = ~(sel ^ c_cur); end
      default:   r.wr = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bop_mask.sv
module bop_mask #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bop_pick.sv
module bop_pick #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  output logic              sel
);
  assign sel = |(data & mask);
endmodule

// File: rtl/bop_merge.sv
module bop_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic              wr,
  input  logic              bit_val,
  output logic [DATA_W-1:0] merged
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (wr && mask[i]) ? bit_val : data[i];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] data_in,
  input  logic              c_in,
  input  logic              z_in,
  output logic [DATA_W-1:0] data_out,
  output logic              store_en,
  output logic              c_out,
  output logic              z_out
);

  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] mask_w;
  logic              sel_w;
  bop_res_t          res_w;
  logic [DATA_W-1:0] merged_w;

  bop_mask #(.DATA_W(DATA_W)) u_mask (
    .idx  (bit_idx),
    .mask (mask_w)
  );

  bop_pick #(.DATA_W(DATA_W)) u_pick (
    .data (data_in),
    .mask (mask_w),
    .sel  (sel_w)
  );

  assign res_w = bop_eval(op_code, sel_w, c_in, z_in);

  bop_merge #(.DATA_W(DATA_W)) u_merge (
    .data    (data_in),
    .mask    (mask_w),
    .wr      (res_w.wr),
    .bit_val (res_w.bit_val),
    .merged  (merged_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      store_en <= 1'b0;
      c_out    <= 1'b0;
      z_out    <= 1'b0;
    end else begin
      data_out <= merged_w;
      store_en <= res_w.wr;
      c_out    <= res_w.c_val;
      z_out    <= res_w.z_val;
    end
  end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_code,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [DATA_W-1:0] data_in,
  input logic              c_in,
  input logic              z_in,
  input logic [DATA_W-1:0] data_out,
  input logic              store_en,
  input logic              c_out,
  input logic              z_out,
  input logic [DATA_W-1:0] mask_w,
  input logic              sel_w
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R3: at most one bit differs from the captured operand
  a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $countones(data_out ^ $past(data_in)) <= 1);

  // R3: any change sits at the decoded position
  a_r3_position: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> ((data_out ^ $past(data_in)) & ~$past(mask_w)) == '0);

  // R3: the decoded position follows the index
  a_r3_mask_idx: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> $past(mask_w[bit_idx]) && $onehot0($past(mask_w)));

  // R9: store window
  a_r9_store_codes: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> store_en == ($past(op_code) inside {[4'd3:4'd13]}));

  // R10: zero passes through except on test
  a_r10_z_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_code) != 4'd0) |-> z_out == $past(z_in));

  // R10: carry passes through except on loads
  a_r10_c_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !($past(op_code) inside {4'd1, 4'd2})) |-> c_out == $past(c_in));

  // R4: test result
  a_r4_test_z: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_code) == 4'd0) |-> z_out == !$past(sel_w));

  // R5: load result
  a_r5_load_c: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_code) == 4'd1) |-> c_out == $past(sel_w));

  // R6: store-carry result at the target bit
  a_r6_store_c: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_code) == 4'd3) |->
      |(data_out & $past(mask_w)) == $past(c_in));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .bit_idx  (bit_idx),
  .data_in  (data_in),
  .c_in     (c_in),
  .z_in     (z_in),
  .data_out (data_out),
  .store_en (store_en),
  .c_out    (c_out),
  .z_out    (z_out),
  .mask_w   (mask_w),
  .sel_w    (sel_w)
);

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] data_in = 8'd0;
  logic       c_in = 1'b0;
  logic       z_in = 1'b0;
  logic [7:0] data_out;
  logic       store_en, c_out, z_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit        have_exp = 0;
  int        e_d, e_we, e_c, e_z, e_op;
  int        m_c;  // model-held carry for chained runs

  always #2.5 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .bit_idx(bit_idx),
    .data_in(data_in), .c_in(c_in), .z_in(z_in),
    .data_out(data_out), .store_en(store_en), .c_out(c_out), .z_out(z_out)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R2,R4";
      1, 2: return "R2,R5";
      3, 4: return "R2,R6,R9";
      5, 6, 7: return "R2,R7,R9";
      8, 9, 10, 11, 12, 13: return "R2,R8,R9";
      default: return "R2,R11";
    endcase
  endfunction

  // Behavioural reference built from the requirement text.
  task automatic model(input int op, input int idx, input int d, input int c,
                       input int z, output int od, output int owe,
                       output int oc, output int oz);
    int b, nb;
    b = (d >> idx) & 1;
    nb = b; owe = 0; oc = c; oz = z;
    case (op)
      0: oz = (b == 0) ? 1 : 0;
      1: oc = b;
      2: oc = 1 - b;
      3: begin nb = c; owe = 1; end
      4: begin nb = 1 - c; owe = 1; end
      5: begin nb = 1; owe = 1; end
      6: begin nb = 0; owe = 1; end
      7: begin nb = 1 - b; owe = 1; end
      8: begin nb = b * c; owe = 1; end
      9: begin nb = 1 - b * c; owe = 1; end
      10: begin nb = (b + c > 0) ? 1 : 0; owe = 1; end
      11: begin nb = (b + c > 0) ? 0 : 1; owe = 1; end
      12: begin nb = (b != c) ? 1 : 0; owe = 1; end
      13: begin nb = (b != c) ? 0 : 1; owe = 1; end
      default: ;
    endcase
    od = d;
    if (owe != 0) od = (nb != 0) ? (d | (1 << idx)) : (d & ~(1 << idx) & 255);
  endtask

  task automatic compare_now();
    compared++;
    if (int'(data_out) != e_d || int'(store_en) != e_we ||
        int'(c_out) != e_c || int'(z_out) != e_z) begin
      mismatched++;
      $display("FAIL %s,R3,R10 op=%0d: got d=%02h we=%0d c=%0d z=%0d exp d=%02h we=%0d c=%0d z=%0d",
               req_of(e_op), e_op, data_out, store_en, c_out, z_out,
               e_d, e_we, e_c, e_z);
    end
  endtask

  // One operation per cycle, driven and compared at the falling edge.
  task automatic step(input int op, input int idx, input int d,
                      input int c, input int z);
    @(negedge clk);
    if (have_exp) compare_now();
    op_code = op[3:0]; bit_idx = idx[2:0]; data_in = d[7:0];
    c_in = c[0]; z_in = z[0];
    model(op, idx, d, c, z, e_d, e_we, e_c, e_z);
    e_op = op;
    have_exp = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (have_exp) compare_now();
    have_exp = 0;
  endtask

  initial begin
    // R1: reset state with busy inputs
    op_code = 4'd5; data_in = 8'hA5; c_in = 1'b1; z_in = 1'b1;
    repeat (3) @(negedge clk);
    compared++;
    if (data_out !== 8'h00 || store_en !== 1'b0 || c_out !== 1'b0 || z_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset: got d=%02h we=%0d c=%0d z=%0d exp all zero",
               data_out, store_en, c_out, z_out);
    end
    rst_n = 1'b1;

    // Every op code on every bit position, two operand patterns, all flag inputs
    for (int op = 0; op < 16; op++)
      for (int idx = 0; idx < 8; idx++)
        for (int fl = 0; fl < 4; fl++) begin
          step(op, idx, 8'h5A, fl & 1, fl >> 1);
          step(op, idx, 8'hA5, fl & 1, fl >> 1);
        end

    // R11: reserved codes on all-ones and all-zero bytes
    step(14, 3, 255, 1, 0);
    step(15, 7, 0, 0, 1);

    // Chained carry: c_out of one op feeds c_in of the next (R5, R6, R8)
    flush();
    m_c = 0;
    for (int k = 0; k < 400; k++) begin
      int op, idx, d, od, owe, oc, oz;
      op  = ((k % 3) == 0) ? 1 + (k % 2) : 3 + ($urandom % 11);
      idx = $urandom % 8;
      d   = $urandom % 256;
      @(negedge clk);
      if (have_exp) compare_now();
      op_code = op[3:0]; bit_idx = idx[2:0]; data_in = d[7:0];
      c_in = c_out; z_in = 1'b0;
      model(op, idx, d, m_c, 0, od, owe, oc, oz);
      e_d = od; e_we = owe; e_c = oc; e_z = oz; e_op = op;
      m_c = oc;
      have_exp = 1;
    end

    // Random mix
    for (int k = 0; k < 800; k++)
      step($urandom % 16, $urandom % 8, $urandom % 256, $urandom % 2, $urandom % 2);
    flush();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule